// File: doc/BRIEF.md
# Tile Bin Memory Allocator

This block manages a pool of binning memory that a tiled renderer uses to store per-tile command lists. Software loads a configuration made of a pool base address, a pool size in bytes and the number of tiles across and down. Every tile owns one fixed 32-byte starting block. These blocks sit back to back at the bottom of the pool in row-major tile order. A client sends a tile coordinate and receives the address of that tile's starting block.

When a tile list fills its current block, the client asks for another block. Extra blocks come from the space above the per-tile region, one 32-byte block per grant, at rising addresses. The block keeps a count of the bytes still free in the pool and drives it on a status output. A request that finds less than one block free is refused. A refusal also raises a sticky out-of-memory interrupt, which stays high until software clears it or loads a new configuration.

Both request paths use valid/ready handshakes. Each has a one-entry registered result stage. A request is taken only on a cycle where both valid and ready are high. Ready is low while a result is waiting that the consumer has not accepted, and it is also low during a configuration load. While a result waits with its ready low, the result does not change. Configuration, interrupt and status pins are plain signals with no handshake.

Top module: `binpool_alloc`

## Requirements
- R1: After reset, both result valids are low, the free-byte count is 0 and the interrupt is low.
- R2: A configuration load sets the free-byte count to the pool size minus 32 × tiles_x × tiles_y, or to 0 when the pool is smaller than that. It also clears the interrupt, and the new values are visible one cycle after the load.
- R3: An accepted tile request (x, y) returns, one cycle later, the address base + (y × tiles_x + x) × 32.
- R4: A tile request with x ≥ tiles_x or y ≥ tiles_y returns the out-of-range flag set to 1. An in-range request returns it set to 0.
- R5: The first granted extra block after a configuration is at base + 32 × tiles_x × tiles_y. Each later grant is 32 bytes above the previous one. Each grant lowers the free-byte count by 32 and returns the ok flag as 1.
- R6: A block request that finds fewer than 32 bytes free returns the ok flag as 0 with address 0. It leaves the free-byte count and the next grant address unchanged.
- R7: A refused block request sets the interrupt. The interrupt stays set until the clear input is pulsed. If a refusal and a clear fall in the same cycle, the interrupt stays set.
- R8: While a result is valid and its ready is low, the matching request ready is low. The result address and flag hold steady, and a request held during that time is not consumed.
- R9: During a configuration load, both request readies are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | One-cycle strobe that loads the configuration |
| cfg_base | input | ADDR_W | Pool base address |
| cfg_size | input | SIZE_W | Pool size in bytes |
| cfg_tiles_x | input | TX_W | Number of tiles across |
| cfg_tiles_y | input | TY_W | Number of tiles down |
| tq_valid | input | 1 | Tile address request valid |
| tq_ready | output | 1 | Tile address request ready |
| tq_x | input | TX_W | Requested tile column |
| tq_y | input | TY_W | Requested tile row |
| ta_valid | output | 1 | Tile address result valid |
| ta_ready | input | 1 | Tile address result ready |
| ta_addr | output | ADDR_W | Starting block address of the tile |
| ta_oob | output | 1 | Coordinate lies outside the configured grid |
| br_valid | input | 1 | Extra block request valid |
| br_ready | output | 1 | Extra block request ready |
| bg_valid | output | 1 | Block grant result valid |
| bg_ready | input | 1 | Block grant result ready |
| bg_addr | output | ADDR_W | Granted block address (0 when refused) |
| bg_ok | output | 1 | 1 = block granted, 0 = refused |
| pool_left | output | SIZE_W | Bytes still free in the pool |
| oom_irq | output | 1 | Sticky out-of-memory interrupt |
| oom_clr | input | 1 | Clears the interrupt |

## Verification
Two things can happen in the same cycle: a block request that gets refused, and a software clear of the interrupt. The bench provokes this by exhausting the pool and then raising the clear input on the same cycle as the next request. It expects the interrupt to remain set. It also pairs a clear with a successful grant and expects the interrupt to drop. Random sequences apply the clear at random on block requests, and a bench model tracks the expected interrupt, free count and next address after every step.

// File: rtl/binpool_pkg.sv
package binpool_pkg;
  localparam int unsigned BLK_BYTES = 32;
  localparam int unsigned BLK_SHIFT = 5;

  typedef enum logic {
    GRANT_REFUSED = 1'b0,
    GRANT_OK      = 1'b1
  } grant_e;
endpackage

// File: rtl/binpool_tile_addr.sv
module binpool_tile_addr
  import binpool_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TX_W   = 4,
  parameter int TY_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [ADDR_W-1:0] base,
  input  logic [TX_W-1:0]   tiles_x,
  input  logic [TY_W-1:0]   tiles_y,
  input  logic              tq_valid,
  output logic              tq_ready,
  input  logic [TX_W-1:0]   tq_x,
  input  logic [TY_W-1:0]   tq_y,
  output logic              ta_valid,
  input  logic              ta_ready,
  output logic [ADDR_W-1:0] ta_addr,
  output logic              ta_oob
);
  localparam int IDX_W = TX_W + TY_W;
  localparam int OFF_W = IDX_W + BLK_SHIFT;

  logic             fire;
  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] off;

  assign tq_ready = !hold && (!ta_valid || ta_ready);
  assign fire     = tq_valid && tq_ready;
  assign idx      = IDX_W'(tq_y) * IDX_W'(tiles_x) + IDX_W'(tq_x);
  assign off      = {idx, {BLK_SHIFT{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ta_valid <= 1'b0;
      ta_addr  <= '0;
      ta_oob   <= 1'b0;
    end else if (fire) begin
      ta_valid <= 1'b1;
      ta_addr  <= base + ADDR_W'(off);
      ta_oob   <= (tq_x >= tiles_x) || (tq_y >= tiles_y);
    end else if (ta_ready) begin
      ta_valid <= 1'b0;
    end
  end

  // R8: a stalled tile result holds its contents
  a_r8_tile_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ta_valid && !ta_ready) |=> (ta_valid && $stable(ta_addr) && $stable(ta_oob)));
endmodule

// File: rtl/binpool_pool.sv
module binpool_pool
  import binpool_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 24,
  parameter int REG_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [REG_W-1:0]  region_bytes,
  input  logic              br_valid,
  output logic              br_ready,
  output logic              bg_valid,
  input  logic              bg_ready,
  output logic [ADDR_W-1:0] bg_addr,
  output logic              bg_ok,
  output logic [SIZE_W-1:0] pool_left,
  output logic              oom_irq,
  input  logic              oom_clr
);
  logic [ADDR_W-1:0] next_q;
  logic [SIZE_W-1:0] region_sz;
  logic              fire;
  grant_e            verdict;

  assign region_sz = SIZE_W'(region_bytes);
  assign br_ready  = !cfg_load && (!bg_valid || bg_ready);
  assign fire      = br_valid && br_ready;
  assign verdict   = (pool_left >= SIZE_W'(BLK_BYTES)) ? GRANT_OK : GRANT_REFUSED;

  // grant result stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bg_valid <= 1'b0;
      bg_addr  <= '0;
      bg_ok    <= 1'b0;
    end else if (fire) begin
      bg_valid <= 1'b1;
      bg_ok    <= (verdict == GRANT_OK);
      bg_addr  <= (verdict == GRANT_OK) ? next_q : '0;
    end else if (bg_ready) begin
      bg_valid <= 1'b0;
    end
  end

  // pool bookkeeping and interrupt
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_q    <= '0;
      pool_left <= '0;
      oom_irq   <= 1'b0;
    end else if (cfg_load) begin
      next_q    <= cfg_base + ADDR_W'(region_bytes);
      pool_left <= (cfg_size >= region_sz) ? (cfg_size - region_sz) : '0;
      oom_irq   <= 1'b0;
    end else begin
      if (fire && verdict == GRANT_OK) begin
        next_q    <= next_q + ADDR_W'(BLK_BYTES);
        pool_left <= pool_left - SIZE_W'(BLK_BYTES);
      end
      if (fire && verdict == GRANT_REFUSED) oom_irq <= 1'b1;
      else if (oom_clr)                     oom_irq <= 1'b0;
    end
  end

  // R2: a load always leaves the interrupt low
  a_r2_cfg_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !oom_irq);
  // R5: a grant spends exactly one block
  a_r5_grant_step: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_ready && pool_left >= SIZE_W'(BLK_BYTES))
      |=> (bg_ok && pool_left == $past(pool_left) - SIZE_W'(BLK_BYTES)));
  // R6/R7: a refusal keeps the count and raises the interrupt
  a_r6_refuse_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_ready && pool_left < SIZE_W'(BLK_BYTES))
      |=> (!bg_ok && bg_addr == '0 && $stable(pool_left) && oom_irq));
  // R7: the interrupt is sticky
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (oom_irq && !oom_clr && !cfg_load) |=> oom_irq);
  // R8: a stalled grant holds its contents
  a_r8_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_valid && !bg_ready) |=> (bg_valid && $stable(bg_addr) && $stable(bg_ok)));
endmodule

// File: rtl/binpool_alloc.sv
module binpool_alloc
  import binpool_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 24,
  parameter int TX_W   = 4,
  parameter int TY_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [TX_W-1:0]   cfg_tiles_x,
  input  logic [TY_W-1:0]   cfg_tiles_y,
  input  logic              tq_valid,
  output logic              tq_ready,
  input  logic [TX_W-1:0]   tq_x,
  input  logic [TY_W-1:0]   tq_y,
  output logic              ta_valid,
  input  logic              ta_ready,
  output logic [ADDR_W-1:0] ta_addr,
  output logic              ta_oob,
  input  logic              br_valid,
  output logic              br_ready,
  output logic              bg_valid,
  input  logic              bg_ready,
  output logic [ADDR_W-1:0] bg_addr,
  output logic              bg_ok,
  output logic [SIZE_W-1:0] pool_left,
  output logic              oom_irq,
  input  logic              oom_clr
);
  localparam int IDX_W = TX_W + TY_W;
  localparam int REG_W = IDX_W + BLK_SHIFT;

  logic [ADDR_W-1:0] base_q;
  logic [TX_W-1:0]   tx_q;
  logic [TY_W-1:0]   ty_q;
  logic [IDX_W-1:0]  ntiles_in;
  logic [REG_W-1:0]  region_in;

  assign ntiles_in = IDX_W'(cfg_tiles_x) * IDX_W'(cfg_tiles_y);
  assign region_in = {ntiles_in, {BLK_SHIFT{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      tx_q   <= '0;
      ty_q   <= '0;
    end else if (cfg_load) begin
      base_q <= cfg_base;
      tx_q   <= cfg_tiles_x;
      ty_q   <= cfg_tiles_y;
    end
  end

  binpool_tile_addr #(.ADDR_W(ADDR_W), .TX_W(TX_W), .TY_W(TY_W)) u_tile (
    .clk(clk), .rst_n(rst_n), .hold(cfg_load),
    .base(base_q), .tiles_x(tx_q), .tiles_y(ty_q),
    .tq_valid(tq_valid), .tq_ready(tq_ready), .tq_x(tq_x), .tq_y(tq_y),
    .ta_valid(ta_valid), .ta_ready(ta_ready), .ta_addr(ta_addr), .ta_oob(ta_oob)
  );

  binpool_pool #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .REG_W(REG_W)) u_pool (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_base(cfg_base), .cfg_size(cfg_size), .region_bytes(region_in),
    .br_valid(br_valid), .br_ready(br_ready),
    .bg_valid(bg_valid), .bg_ready(bg_ready), .bg_addr(bg_addr), .bg_ok(bg_ok),
    .pool_left(pool_left), .oom_irq(oom_irq), .oom_clr(oom_clr)
  );

  // R9: nothing is accepted while a configuration loads
  a_r9_load_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |-> (!(tq_valid && tq_ready) && !(br_valid && br_ready)));
endmodule

// File: tb/tb_binpool_alloc.sv
module tb_binpool_alloc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [23:0] cfg_size = '0;
  logic [3:0]  cfg_tiles_x = '0;
  logic [3:0]  cfg_tiles_y = '0;
  logic        tq_valid = 1'b0;
  logic        tq_ready;
  logic [3:0]  tq_x = '0;
  logic [3:0]  tq_y = '0;
  logic        ta_valid;
  logic        ta_ready = 1'b1;
  logic [31:0] ta_addr;
  logic        ta_oob;
  logic        br_valid = 1'b0;
  logic        br_ready;
  logic        bg_valid;
  logic        bg_ready = 1'b1;
  logic [31:0] bg_addr;
  logic        bg_ok;
  logic [23:0] pool_left;
  logic        oom_irq;
  logic        oom_clr = 1'b0;

  int checks = 0;
  int fails  = 0;

  // bench model
  logic [31:0] m_base;
  logic [31:0] m_next;
  int          m_tx, m_ty;
  longint      m_left;
  bit          m_oom;

  always #4 clk = ~clk;

  binpool_alloc dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .cfg_tiles_x(cfg_tiles_x), .cfg_tiles_y(cfg_tiles_y),
    .tq_valid(tq_valid), .tq_ready(tq_ready), .tq_x(tq_x), .tq_y(tq_y),
    .ta_valid(ta_valid), .ta_ready(ta_ready), .ta_addr(ta_addr), .ta_oob(ta_oob),
    .br_valid(br_valid), .br_ready(br_ready), .bg_valid(bg_valid),
    .bg_ready(bg_ready), .bg_addr(bg_addr), .bg_ok(bg_ok),
    .pool_left(pool_left), .oom_irq(oom_irq), .oom_clr(oom_clr)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_tile(input logic [31:0] b, input int tx, input int x, input int y);
    return b + 32'((y * tx + x) * 32);
  endfunction

  task automatic do_cfg(input logic [31:0] b, input int size, input int tx, input int ty);
    longint region;
    @(negedge clk);
    cfg_load = 1'b1; cfg_base = b; cfg_size = 24'(size);
    cfg_tiles_x = 4'(tx); cfg_tiles_y = 4'(ty);
    tq_valid = 1'b1; br_valid = 1'b1;
    #1;
    chk(!tq_ready && !br_ready, "R9 readies low during load", {tq_ready, br_ready}, 0);
    @(negedge clk);
    cfg_load = 1'b0; tq_valid = 1'b0; br_valid = 1'b0;
    region = longint'(tx * ty * 32);
    m_base = b; m_tx = tx; m_ty = ty;
    m_next = b + 32'(region);
    m_left = (size >= region) ? size - region : 0;
    m_oom  = 1'b0;
    chk(pool_left == 24'(m_left), "R2 free count after load", pool_left, m_left);
    chk(!oom_irq, "R2 interrupt cleared by load", oom_irq, 0);
    chk(!ta_valid && !bg_valid, "R9 no request taken during load", {ta_valid, bg_valid}, 0);
  endtask

  task automatic tile_req(input int x, input int y);
    logic [31:0] e;
    bit eo;
    @(negedge clk);
    tq_valid = 1'b1; tq_x = 4'(x); tq_y = 4'(y);
    @(negedge clk);
    tq_valid = 1'b0;
    e  = exp_tile(m_base, m_tx, x, y);
    eo = (x >= m_tx) || (y >= m_ty);
    chk(ta_valid, "R3 tile result valid", ta_valid, 1);
    chk(ta_addr == e, "R3 tile address", ta_addr, e);
    chk(ta_oob == eo, "R4 out-of-range flag", ta_oob, eo);
  endtask

  task automatic blk_req(input bit clr);
    bit          eok;
    logic [31:0] ea;
    @(negedge clk);
    br_valid = 1'b1; oom_clr = clr;
    @(negedge clk);
    br_valid = 1'b0; oom_clr = 1'b0;
    if (m_left >= 32) begin
      eok = 1'b1; ea = m_next; m_next += 32; m_left -= 32;
      if (clr) m_oom = 1'b0;
    end else begin
      eok = 1'b0; ea = '0; m_oom = 1'b1;
    end
    chk(bg_valid, "R5 grant result valid", bg_valid, 1);
    chk(bg_ok == eok, eok ? "R5 grant ok flag" : "R6 refusal flag", bg_ok, eok);
    chk(bg_addr == ea, eok ? "R5 grant address" : "R6 refused address zero", bg_addr, ea);
    chk(pool_left == 24'(m_left), eok ? "R5 free count step" : "R6 free count kept", pool_left, m_left);
    chk(oom_irq == m_oom, clr ? "R7 set versus clear" : "R7 interrupt state", oom_irq, m_oom);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    summary();
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ta_valid && !bg_valid, "R1 valids low after reset", {ta_valid, bg_valid}, 0);
    chk(pool_left == 0, "R1 free count zero after reset", pool_left, 0);
    chk(!oom_irq, "R1 interrupt low after reset", oom_irq, 0);

    // full frame grid, two spare blocks
    do_cfg(32'h0010_0000, 80 * 32 + 64, 10, 8);
    tile_req(0, 0);
    tile_req(9, 7);
    tile_req(3, 2);
    tile_req(10, 0);
    tile_req(0, 8);
    blk_req(1'b0);
    blk_req(1'b0);
    blk_req(1'b0);   // refused, interrupt rises
    blk_req(1'b0);   // still refused, interrupt stays
    blk_req(1'b1);   // refusal and clear in the same cycle
    @(negedge clk); oom_clr = 1'b1;
    @(negedge clk); oom_clr = 1'b0; m_oom = 1'b0;
    chk(!oom_irq, "R7 clear drops interrupt", oom_irq, 0);

    // pool smaller than the per-tile region
    do_cfg(32'h0020_0000, 100, 10, 8);
    blk_req(1'b0);

    // back-pressure on the grant stage
    do_cfg(32'h0030_0000, 4 * 32 + 256, 2, 2);
    @(negedge clk);
    bg_ready = 1'b0; br_valid = 1'b1;
    @(negedge clk);
    chk(bg_valid && bg_addr == m_next, "R8 first stalled grant", bg_addr, m_next);
    chk(!br_ready, "R8 ready low while stalled", br_ready, 0);
    held = bg_addr;
    @(negedge clk);
    chk(bg_addr == held && bg_ok, "R8 grant held", bg_addr, held);
    chk(pool_left == 24'(m_left - 32), "R8 held request not consumed", pool_left, m_left - 32);
    bg_ready = 1'b1;
    @(negedge clk);
    br_valid = 1'b0;
    chk(bg_addr == m_next + 32, "R8 second grant after release", bg_addr, m_next + 32);
    chk(pool_left == 24'(m_left - 64), "R5 two blocks spent", pool_left, m_left - 64);
    m_next += 64; m_left -= 64;
    blk_req(1'b1);   // clear alongside a successful grant

    // random configurations and traffic
    for (int c = 0; c < 20; c++) begin
      int tx, ty, sz;
      tx = 1 + int'($urandom % 10);
      ty = 1 + int'($urandom % 8);
      sz = tx * ty * 32 + int'($urandom % 6) * 32 + (($urandom % 3 == 0) ? int'($urandom % 32) : 0);
      do_cfg($urandom & 32'h0FFF_FFE0, sz, tx, ty);
      for (int k = 0; k < 12; k++) begin
        if ($urandom % 2 == 0)
          tile_req(int'($urandom % (tx + 1)), int'($urandom % (ty + 1)));
        else
          blk_req($urandom % 4 == 0);
      end
    end
    summary();
  end
endmodule